// File: doc/BRIEF.md
# Seconds-Counting Real-Time Clock with Alarm

This peripheral keeps time as one 32-bit unsigned count of seconds. A prescaler divides a reference tick stream (nominally 32768 Hz, delivered as one-cycle pulses in the bus clock domain) down to one advance per second. The count runs only while the enable bit in the control word is set. Software sets the time by writing a load word and reads it back through a separate count word.

An alarm compares the count against a programmable match word. When a seconds advance makes the count equal to the match value, a sticky raw alarm flag is set. A mask word gates the raw flags into a masked status. A single level interrupt output is high while any masked flag is set. Software acknowledges the alarm by writing a one to the clear word.

Access is through a 32-bit APB-style register port with zero wait states. A write commits on the clock edge that ends the access phase. Read data is valid during the access phase.

Top module: `sec_rtc`

## Requirements
- R1: After reset, the count, match, control, mask and raw status all read 0, and irq_o is low.
- R2: The word map is fixed: count at byte offset 0x00, match at 0x04, load at 0x08, control at 0x0C (bit 0 = run), mask at 0x10, raw status at 0x14, masked status at 0x18 and clear at 0x1C. In every interrupt word, bit 0 is the alarm. Reads of load, clear, offsets 0x20 and above, and addresses not aligned to a word return 0.
- R3: While control bit 0 is 1, the count increases by one on every PRESCALE-th reference pulse. While it is 0, reference pulses neither change the count nor advance the prescaler.
- R4: A write to the load word sets the count to the written value from the next cycle on, and restarts the prescaler at zero. A load takes priority over a tick that falls on the same edge.
- R5: The count wraps from 0xFFFFFFFF to 0 on a seconds advance.
- R6: The raw alarm bit sets on the advance that makes the count equal to the match word. Loading a value equal to the match word does not set it.
- R7: The raw alarm bit stays set until a write to the clear word with bit 0 = 1. A clear write with bit 0 = 0 leaves it set.
- R8: If an alarm set event and a clearing write fall on the same edge, the raw bit ends up set.
- R9: The masked status reads as raw AND mask. irq_o is high exactly while a masked bit is set.
- R10: Writes to the count, raw status and masked status offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and logic clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | One-cycle pulse per reference period |
| psel_i | input | 1 | Peripheral select |
| penable_i | input | 1 | Access phase |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | ADDR_W | Byte address |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data |
| irq_o | output | 1 | Masked alarm interrupt |

## Verification
The count is driven by a counted number of reference pulses. Three cases are run: pulses with the run bit clear, pulses after a mid-period reload, and pulses across the all-ones boundary. Together they separate a prescaler that holds while idle from one that drifts, and a reload that restarts the prescaler from one that only replaces the count. The alarm is tried three ways: reached by ticking, hit by a direct load of the match value, and hit on the same edge as a clear. These cases separate a compare on the tick from a compare on the level, and show which of set and clear has priority. Mask toggles and writes of zero to the clear and status words show the difference between gating and clearing.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned NUM_IRQ = 1;
  localparam int unsigned ALARM_BIT = 0;

  // word indices (byte offset / 4)
  localparam int unsigned IDX_COUNT = 0;
  localparam int unsigned IDX_MATCH = 1;
  localparam int unsigned IDX_LOAD  = 2;
  localparam int unsigned IDX_CTRL  = 3;
  localparam int unsigned IDX_MASK  = 4;
  localparam int unsigned IDX_RAW   = 5;
  localparam int unsigned IDX_MSTAT = 6;
  localparam int unsigned IDX_CLR   = 7;

  typedef struct packed {
    logic load;
    logic match;
    logic ctrl;
    logic mask;
    logic clr;
  } wr_strobe_t;
endpackage

// File: rtl/sec_rtc_regs.sv
module sec_rtc_regs
  import sec_rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [ADDR_W-1:0]  paddr_i,
  input  logic [DATA_W-1:0]  pwdata_i,
  output logic [DATA_W-1:0]  prdata_o,
  input  logic [DATA_W-1:0]  cnt_i,
  input  logic [NUM_IRQ-1:0] raw_i,
  output wr_strobe_t         wr_o,
  output logic               en_o,
  output logic [DATA_W-1:0]  match_o,
  output logic [NUM_IRQ-1:0] mask_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic             aligned;
  logic [IDX_W-1:0] idx;
  logic             wr_acc;

  assign aligned = (paddr_i[1:0] == 2'b00);
  assign idx     = paddr_i[ADDR_W-1:2];
  assign wr_acc  = psel_i & penable_i & pwrite_i & aligned;

  assign wr_o.load  = wr_acc && (idx == IDX_W'(IDX_LOAD));
  assign wr_o.match = wr_acc && (idx == IDX_W'(IDX_MATCH));
  assign wr_o.ctrl  = wr_acc && (idx == IDX_W'(IDX_CTRL));
  assign wr_o.mask  = wr_acc && (idx == IDX_W'(IDX_MASK));
  assign wr_o.clr   = wr_acc && (idx == IDX_W'(IDX_CLR));

  logic               en_q;
  logic [DATA_W-1:0]  match_q;
  logic [NUM_IRQ-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      match_q <= '0;
      mask_q  <= '0;
    end else begin
      if (wr_o.ctrl)  en_q    <= pwdata_i[0];
      if (wr_o.match) match_q <= pwdata_i;
      if (wr_o.mask)  mask_q  <= pwdata_i[NUM_IRQ-1:0];
    end
  end

  assign en_o    = en_q;
  assign match_o = match_q;
  assign mask_o  = mask_q;

  always_comb begin
    prdata_o = '0;
    if (aligned) begin
      if (idx == IDX_W'(IDX_COUNT))      prdata_o = cnt_i;
      else if (idx == IDX_W'(IDX_MATCH)) prdata_o = match_q;
      else if (idx == IDX_W'(IDX_CTRL))  prdata_o[0] = en_q;
      else if (idx == IDX_W'(IDX_MASK))  prdata_o[NUM_IRQ-1:0] = mask_q;
      else if (idx == IDX_W'(IDX_RAW))   prdata_o[NUM_IRQ-1:0] = raw_i;
      else if (idx == IDX_W'(IDX_MSTAT)) prdata_o[NUM_IRQ-1:0] = raw_i & mask_q;
    end
  end

  // R2
  ctrl_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o.ctrl |=> (en_o == $past(pwdata_i[0])));

  // R2
  match_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_o.match |=> $stable(match_o));
endmodule

// File: rtl/sec_rtc_prescaler.sv
module sec_rtc_prescaler #(
  parameter int unsigned PRESCALE = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ref_tick_i,
  input  logic restart_i,
  output logic tick_o
);
  generate
    if (PRESCALE <= 1) begin : g_direct
      assign tick_o = en_i & ref_tick_i & ~restart_i;
    end else begin : g_div
      localparam int unsigned PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

      logic [PW-1:0] presc_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          presc_q <= '0;
        end else if (restart_i) begin
          presc_q <= '0;
        end else if (en_i && ref_tick_i) begin
          presc_q <= (presc_q == LAST) ? '0 : presc_q + 1'b1;
        end
      end

      assign tick_o = en_i & ref_tick_i & ~restart_i & (presc_q == LAST);

      // R3
      idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !restart_i) |=> $stable(presc_q));

      // R4
      restart_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (presc_q == '0));
    end
  endgenerate
endmodule

// File: rtl/sec_rtc_counter.sv
module sec_rtc_counter
  import sec_rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic [DATA_W-1:0] match_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              hit_o
);
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (tick_i)  cnt_q <= cnt_inc;
  end

  // compare the value the count is about to take
  assign hit_o = tick_i & ~load_i & (cnt_inc == match_i);
  assign cnt_o = cnt_q;

  // R4
  load_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_o == $past(load_val_i)));

  // R3
  step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i) |=> (cnt_o == $past(cnt_o) + 1'b1));

  // R5
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && (cnt_o == '1)) |=> (cnt_o == '0));

  // R3
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_o));
endmodule

// File: rtl/sec_rtc_irq.sv
module sec_rtc_irq
  import sec_rtc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] set_i,
  input  logic               clr_i,
  input  logic [NUM_IRQ-1:0] clr_bits_i,
  input  logic [NUM_IRQ-1:0] mask_i,
  output logic [NUM_IRQ-1:0] raw_o,
  output logic               irq_o
);
  logic [NUM_IRQ-1:0] raw_q;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       raw_q[g] <= 1'b0;
      else if (set_i[g])                 raw_q[g] <= 1'b1;
      else if (clr_i && clr_bits_i[g])   raw_q[g] <= 1'b0;
    end

    // R7
    raw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (raw_q[g] && !(clr_i && clr_bits_i[g])) |=> raw_q[g]);

    // R8
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> raw_q[g]);
  end

  assign raw_o = raw_q;
  assign irq_o = |(raw_q & mask_i);

  // R9
  mask_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> !irq_o);
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import sec_rtc_pkg::*;
#(
  parameter int unsigned PRESCALE = 32768,
  parameter int unsigned ADDR_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  output logic              irq_o
);
  wr_strobe_t         wr;
  logic               en;
  logic [DATA_W-1:0]  match;
  logic [NUM_IRQ-1:0] mask;
  logic [NUM_IRQ-1:0] raw;
  logic [NUM_IRQ-1:0] set_vec;
  logic [DATA_W-1:0]  cnt;
  logic               sec_tick;
  logic               hit;

  sec_rtc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .psel_i    (psel_i),
    .penable_i (penable_i),
    .pwrite_i  (pwrite_i),
    .paddr_i   (paddr_i),
    .pwdata_i  (pwdata_i),
    .prdata_o  (prdata_o),
    .cnt_i     (cnt),
    .raw_i     (raw),
    .wr_o      (wr),
    .en_o      (en),
    .match_o   (match),
    .mask_o    (mask)
  );

  sec_rtc_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .ref_tick_i (ref_tick_i),
    .restart_i  (wr.load),
    .tick_o     (sec_tick)
  );

  sec_rtc_counter u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (sec_tick),
    .load_i     (wr.load),
    .load_val_i (pwdata_i),
    .match_i    (match),
    .cnt_o      (cnt),
    .hit_o      (hit)
  );

  always_comb begin
    set_vec = '0;
    set_vec[ALARM_BIT] = hit;
  end

  sec_rtc_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_vec),
    .clr_i      (wr.clr),
    .clr_bits_i (pwdata_i[NUM_IRQ-1:0]),
    .mask_i     (mask),
    .raw_o      (raw),
    .irq_o      (irq_o)
  );

  // R6
  alarm_on_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(raw[ALARM_BIT]) && $stable(match)) |-> (cnt == match));

  // R6
  load_no_alarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr.load && !raw[ALARM_BIT]) |=> !raw[ALARM_BIT]);

  // R9
  irq_needs_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (raw != '0));
endmodule

// File: tb/sec_rtc_bench.sv
`timescale 1ns/1ps
module sec_rtc_bench;
  localparam int unsigned PRESC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [5:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  logic [31:0] act_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  sec_rtc #(.PRESCALE(PRESC), .ADDR_W(6)) u_sec_rtc (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ref_tick_i (ref_tick),
    .psel_i     (psel),
    .penable_i  (penable),
    .pwrite_i   (pwrite),
    .paddr_i    (paddr),
    .pwdata_i   (pwdata),
    .prdata_o   (prdata),
    .irq_o      (irq)
  );

  // monitor: compares read results against expectations in order
  initial begin
    forever begin
      @(posedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        logic [31:0] a;
        logic [31:0] e;
        string t;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", t, a, e);
        end
      end
    end
  end

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d, input bit tick = 1'b0);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1; ref_tick = tick;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; ref_tick = 1'b0;
  endtask

  task automatic expect_read(input logic [5:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1;
    act_q.push_back(prdata);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
  endtask

  task automatic check_irq(input logic e, input string t);
    @(negedge clk);
    #1;
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_irq(1'b0, "R1 irq after reset");
    expect_read(6'h00, 32'h0, "R1 count reset");
    expect_read(6'h04, 32'h0, "R1 match reset");
    expect_read(6'h0C, 32'h0, "R1 ctrl reset");
    expect_read(6'h10, 32'h0, "R1 mask reset");
    expect_read(6'h14, 32'h0, "R1 raw reset");

    // R2 map and zero reads
    bus_write(6'h04, 32'h1234_5678);
    expect_read(6'h04, 32'h1234_5678, "R2 match readback");
    expect_read(6'h08, 32'h0, "R2 load reads zero");
    expect_read(6'h1C, 32'h0, "R2 clear reads zero");
    expect_read(6'h20, 32'h0, "R2 unused offset");
    expect_read(6'h05, 32'h0, "R2 misaligned read");

    // R4 load, R3 disabled counting
    bus_write(6'h08, 32'h100);
    expect_read(6'h00, 32'h100, "R4 load next cycle");
    pulse(8);
    expect_read(6'h00, 32'h100, "R3 no count while disabled");
    bus_write(6'h0C, 32'h1);
    expect_read(6'h0C, 32'h1, "R2 ctrl readback");
    pulse(3);
    expect_read(6'h00, 32'h100, "R3 prescaler held while idle");
    pulse(1);
    expect_read(6'h00, 32'h101, "R3 first second");
    pulse(8);
    expect_read(6'h00, 32'h103, "R3 two more seconds");

    // R4 reload restarts prescaler
    pulse(3);
    bus_write(6'h08, 32'h200);
    pulse(3);
    expect_read(6'h00, 32'h200, "R4 prescaler restarted");
    pulse(1);
    expect_read(6'h00, 32'h201, "R4 full period after reload");

    // R10 write to count ignored
    bus_write(6'h00, 32'hDEAD_BEEF);
    expect_read(6'h00, 32'h201, "R10 count write ignored");

    // R6 alarm
    bus_write(6'h04, 32'h203);
    bus_write(6'h10, 32'h1);
    bus_write(6'h08, 32'h203);
    expect_read(6'h14, 32'h0, "R6 load equal to match no alarm");
    check_irq(1'b0, "R6 irq low after load match");
    bus_write(6'h08, 32'h201);
    pulse(4);
    expect_read(6'h14, 32'h0, "R6 no alarm before match");
    pulse(4);
    expect_read(6'h00, 32'h203, "R6 count at match");
    expect_read(6'h14, 32'h1, "R6 raw set on match tick");
    expect_read(6'h18, 32'h1, "R9 masked status set");
    check_irq(1'b1, "R9 irq high");

    // R7 / R10 clear behaviour
    bus_write(6'h1C, 32'h0);
    expect_read(6'h14, 32'h1, "R7 clear with zero no effect");
    bus_write(6'h14, 32'h0);
    bus_write(6'h18, 32'h0);
    expect_read(6'h14, 32'h1, "R10 status writes ignored");
    bus_write(6'h1C, 32'h1);
    expect_read(6'h14, 32'h0, "R7 clear with one");
    check_irq(1'b0, "R7 irq low after clear");

    // R8 set wins over clear
    bus_write(6'h08, 32'h201);
    pulse(7);
    bus_write(6'h1C, 32'h1, 1'b1);
    expect_read(6'h00, 32'h203, "R8 tick on clear edge");
    expect_read(6'h14, 32'h1, "R8 set wins");

    // R9 mask gating
    bus_write(6'h10, 32'h0);
    expect_read(6'h18, 32'h0, "R9 masked status gated");
    expect_read(6'h14, 32'h1, "R9 raw kept when masked");
    check_irq(1'b0, "R9 irq gated");
    bus_write(6'h10, 32'h1);
    check_irq(1'b1, "R9 irq on unmask");
    bus_write(6'h1C, 32'h1);

    // R5 wrap with alarm at zero
    bus_write(6'h04, 32'h0);
    bus_write(6'h08, 32'hFFFF_FFFF);
    pulse(3);
    expect_read(6'h00, 32'hFFFF_FFFF, "R5 before wrap");
    expect_read(6'h14, 32'h0, "R6 raw clear before wrap");
    pulse(1);
    expect_read(6'h00, 32'h0, "R5 wrapped to zero");
    expect_read(6'h14, 32'h1, "R6 alarm at wrap");

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule